// File: doc/BRIEF.md
# Sleep Wake-On-Pin-Change Detector

This block lets a sleeping device be woken by activity on external pins. Five inputs are watched: a group of four general-purpose pins and one separate input intended for a slowly rising voltage. When the device enters sleep, a one-cycle sleep-entry pulse takes a snapshot of all five levels. From then on, every input is compared with its snapshot on each tick of the always-running low-power clock. An input that differs from its snapshot for three ticks in a row counts as a real change. Shorter disturbances are discarded.

An accepted change produces a one-tick warm-reset request, provided the feature enable allows it. The enable is active low: 1 disables the feature, and that is also its state after power-on. The same event clears a status flag, which tells software after the restart that a pin change caused the reset. Power-on reset and every sleep entry set the flag back to 1. The detector stays armed only from sleep entry until the reset it issues. Pin activity while the device is awake has no effect.

The inputs are assumed to be already synchronous to the low-power clock. The slow-rise analog buffer lies outside this block.

Top module: `wake_pin_monitor`

## Requirements
- R1: While `rst_n` is low and after its release, `wake_rst_o` is 0 and `pin_wake_flag_o` is 1.
- R2: A cycle with `sleep_start_i` high arms the detector, captures the present levels of `pins_i[3:0]` and `slow_pin_i` as the reference, and sets `pin_wake_flag_o` to 1 from the next cycle.
- R3: If an armed input differs from its reference on three consecutive clock samples, and the first of these samples comes after the sleep-entry sample, then `wake_rst_o` is 1 in the cycle that follows the third sample and `pin_wake_flag_o` is 0 from that cycle on.
- R4: A difference that lasts only one or two samples before the input returns to its reference produces no wake pulse, and the flag stays 1.
- R5: `wake_rst_o` is high for exactly one clock. The detector is disarmed afterwards, so further pin changes give no more pulses until the next sleep entry.
- R6: While `wake_dis_i` is 1, a sustained change produces no wake pulse and leaves the flag at 1.
- R7: `slow_pin_i` wakes the device under the same filtering as the four pins. It shares the single enable and the single flag with them.
- R8: Pin changes while not armed (after reset, or after a wake) produce no pulse and do not change the flag.
- R9: A change is detected in both directions: reference 0 going to 1, and reference 1 going to 0.
- R10: A sleep-entry pulse while already armed recaptures the references and restarts the filtering. A level that equals the new reference is not a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running low-power sampling clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| pins_i | input | 4 | Watched general pins, bit i is port bit i |
| slow_pin_i | input | 1 | Watched slow-rise input |
| sleep_start_i | input | 1 | One-cycle pulse when sleep begins |
| wake_dis_i | input | 1 | Feature disable, 1 = disabled, 0 = enabled |
| wake_rst_o | output | 1 | One-cycle warm-reset request |
| pin_wake_flag_o | output | 1 | 0 when the last reset came from a pin change |

## Verification
The hardest case to reach from the ports is a difference that keeps the filter at its last count without tipping it into a wake. Two such cases matter: a two-sample glitch that drops back to the reference just before acceptance, and a re-arm pulse that arrives while the count is partly built up. The directed tasks place the sleep pulse and each pin edge on chosen falling clock edges. Each scenario therefore lands on an exact sample count relative to arming, and the bench checks for the pulse on one specific cycle rather than inside a loose window.

// File: rtl/wake_pkg.sv
// Package: shared types and constants for the wake-on-pin-change detector.
// Assumes: nothing beyond standard SystemVerilog.
package wake_pkg;

    // Detector arming state
    typedef enum logic {
        ST_AWAKE = 1'b0,
        ST_ARMED = 1'b1
    } wake_state_e;

    // Default number of consecutive differing samples needed to accept a change
    localparam int unsigned DEFAULT_FILT_DEPTH = 3;

endpackage

// File: rtl/wake_ref_bank.sv
// Module: wake_ref_bank
// Holds one reference level per watched input, loaded on the sleep-entry
// pulse. Assumes the inputs are synchronous to clk.
module wake_ref_bank #(
    parameter int unsigned NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [NUM_CH-1:0] level_i,
    output logic [NUM_CH-1:0] ref_o
);

    // Capture all channel levels together when sleep begins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_o <= '0;
        end else if (capture_i) begin
            ref_o <= level_i;
        end
    end

endmodule

// File: rtl/wake_glitch_filter.sv
// Module: wake_glitch_filter
// One channel of the glitch filter. It counts consecutive samples where the
// input differs from its reference. hit_o goes high combinationally on the
// sample that completes FILT_DEPTH differing samples, and stays high while the
// difference persists. clear_i holds the count at zero.
// Assumes: FILT_DEPTH >= 1, the input is synchronous to clk.
module wake_glitch_filter #(
    parameter int unsigned FILT_DEPTH = wake_pkg::DEFAULT_FILT_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic level_i,
    input  logic ref_i,
    output logic hit_o
);

    localparam int unsigned CNT_W = $clog2(FILT_DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_DEPTH - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             differs;

    // Compare the live level with the captured reference
    always_comb begin
        differs = level_i ^ ref_i;
    end

    // Count consecutive differing samples, saturating at the last step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clear_i || !differs) begin
            run_cnt <= '0;
        end else if (run_cnt != LAST) begin
            run_cnt <= run_cnt + CNT_W'(1);
        end
    end

    // Accept the change on the sample that completes the run
    always_comb begin
        hit_o = !clear_i && differs && (run_cnt == LAST);
    end

endmodule

// File: rtl/wake_seq_ctrl.sv
// Module: wake_seq_ctrl
// Arming state machine, wake pulse and wake-cause flag. Sleep entry arms the
// detector and sets the flag. An accepted change while armed and enabled
// fires a one-cycle pulse, clears the flag and disarms.
// Assumes: sleep_i is a single-cycle pulse; dis_i is active high (1 = off).
module wake_seq_ctrl
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic hit_any_i,
    input  logic dis_i,
    output logic armed_o,
    output logic wake_o,
    output logic flag_o
);

    wake_state_e state_q;
    logic        fire;

    // Decide whether this sample triggers a wake
    always_comb begin
        fire = (state_q == ST_ARMED) && !sleep_i && hit_any_i && !dis_i;
    end

    // Arming state: sleep arms, a wake disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
        end else if (sleep_i) begin
            state_q <= ST_ARMED;
        end else if (fire) begin
            state_q <= ST_AWAKE;
        end
    end

    // One-cycle warm-reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_o <= 1'b0;
        end else begin
            wake_o <= fire;
        end
    end

    // Wake-cause flag: set by power-on and sleep entry, cleared by pin wake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b1;
        end else if (sleep_i) begin
            flag_o <= 1'b1;
        end else if (fire) begin
            flag_o <= 1'b0;
        end
    end

    // Expose arming for the filter clear
    always_comb begin
        armed_o = (state_q == ST_ARMED);
    end

endmodule

// File: rtl/wake_pin_monitor.sv
// Module: wake_pin_monitor (top)
// Watches NUM_PINS general pins plus one slow-rise input during sleep. It
// captures references on sleep entry, filters each channel, and issues a
// warm-reset pulse with a cleared wake-cause flag on an accepted change.
// Assumes: all inputs are synchronous to the low-power clock clk.
module wake_pin_monitor #(
    parameter int unsigned NUM_PINS   = 4,
    parameter int unsigned FILT_DEPTH = wake_pkg::DEFAULT_FILT_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                slow_pin_i,
    input  logic                sleep_start_i,
    input  logic                wake_dis_i,
    output logic                wake_rst_o,
    output logic                pin_wake_flag_o
);

    localparam int unsigned NUM_CH = NUM_PINS + 1;

    logic [NUM_CH-1:0] level_all;
    logic [NUM_CH-1:0] ref_all;
    logic [NUM_CH-1:0] hit_all;
    logic              armed;
    logic              filt_clear;
    logic              hit_any;

    // Gather all watched channels, slow-rise input on top
    always_comb begin
        level_all = {slow_pin_i, pins_i};
    end

    // Hold the filters idle while disarmed or on a (re)arm sample
    always_comb begin
        filt_clear = !armed || sleep_start_i;
    end

    // Any channel accepting a change
    always_comb begin
        hit_any = |hit_all;
    end

    wake_ref_bank #(
        .NUM_CH (NUM_CH)
    ) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (sleep_start_i),
        .level_i   (level_all),
        .ref_o     (ref_all)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_filt
        wake_glitch_filter #(
            .FILT_DEPTH (FILT_DEPTH)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (filt_clear),
            .level_i (level_all[ch]),
            .ref_i   (ref_all[ch]),
            .hit_o   (hit_all[ch])
        );
    end

    wake_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_i   (sleep_start_i),
        .hit_any_i (hit_any),
        .dis_i     (wake_dis_i),
        .armed_o   (armed),
        .wake_o    (wake_rst_o),
        .flag_o    (pin_wake_flag_o)
    );

endmodule

// File: rtl/wake_pin_monitor_chk.sv
// Module: wake_pin_monitor_chk
// Port-level properties of the wake detector, bound to the top module.
// Assumes: default parameters (three-sample filter).
module wake_pin_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_start_i,
    input logic wake_dis_i,
    input logic wake_rst_o,
    input logic pin_wake_flag_o
);

    // R5: the pulse never lasts two cycles
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst_o |=> !wake_rst_o);

    // R3: a wake pulse comes with a cleared flag
    p_flag_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst_o |-> !pin_wake_flag_o);

    // R2: sleep entry sets the flag
    p_flag_set_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_start_i |=> pin_wake_flag_o);

    // R6: a pulse is issued only when the feature was enabled
    p_no_wake_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst_o |-> !$past(wake_dis_i));

    // R8: a cleared flag stays cleared until the next sleep entry
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_wake_flag_o && !sleep_start_i) |=> !pin_wake_flag_o);

    // R10: no (re)arm pulse within the three samples that led to a wake
    p_rearm_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst_o |-> (!$past(sleep_start_i, 1) && !$past(sleep_start_i, 2)
                        && !$past(sleep_start_i, 3)));

endmodule

bind wake_pin_monitor wake_pin_monitor_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sleep_start_i   (sleep_start_i),
    .wake_dis_i      (wake_dis_i),
    .wake_rst_o      (wake_rst_o),
    .pin_wake_flag_o (pin_wake_flag_o)
);

// File: tb/tb_wake_pin_monitor.sv
// Directed bench for wake_pin_monitor. Inputs change on falling edges and
// outputs are sampled on falling edges.
module tb_wake_pin_monitor;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pins;
    logic       slow_pin;
    logic       sleep_start;
    logic       wake_dis;
    logic       wake_rst;
    logic       flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    wake_pin_monitor dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .pins_i          (pins),
        .slow_pin_i      (slow_pin),
        .sleep_start_i   (sleep_start),
        .wake_dis_i      (wake_dis),
        .wake_rst_o      (wake_rst),
        .pin_wake_flag_o (flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] p, input logic s);
        rst_n = 1'b0; pins = p; slow_pin = s; sleep_start = 1'b0; wake_dis = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    // Pulse sleep entry; returns at the falling edge after the arming sample
    task automatic arm();
        sleep_start = 1'b1;
        step();
        sleep_start = 1'b0;
    endtask

    // Step n cycles and report whether any wake pulse was seen
    task automatic watch(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            step();
            if (wake_rst) seen = 1'b1;
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; pins = 4'h0; slow_pin = 1'b0; sleep_start = 1'b0; wake_dis = 1'b1;
        repeat (2) step();
        check(wake_rst == 1'b0, "R1 wake in reset", wake_rst, 0);
        check(flag == 1'b1, "R1 flag in reset", flag, 1);
        rst_n = 1'b1;
        step();
        check(wake_rst == 1'b0 && flag == 1'b1, "R1 after release", {wake_rst, flag}, 1);
    endtask

    // Sustained change on general pin `bit_i` away from reference `refv`
    task automatic t_sustained(input int bit_i, input logic refv);
        bit seen;
        do_reset({4{refv}}, refv);
        arm();
        pins[bit_i] = ~refv;
        step(); step();
        check(wake_rst == 1'b0, "R3 no wake after two samples", wake_rst, 0);
        step();
        check(wake_rst == 1'b1, refv ? "R9 wake on 1->0" : "R3 wake on third sample", wake_rst, 1);
        check(flag == 1'b0, "R3 flag cleared", flag, 0);
        step();
        check(wake_rst == 1'b0, "R5 pulse one cycle", wake_rst, 0);
        pins[bit_i] = refv;
        watch(4, seen);
        pins[bit_i] = ~refv;
        watch(6, seen);
        check(!seen, "R5 disarmed after wake", seen, 0);
        check(flag == 1'b0, "R8 flag unchanged while awake", flag, 0);
    endtask

    task automatic t_glitches();
        bit seen;
        do_reset(4'h0, 1'b0);
        arm();
        pins[2] = 1'b1; step(); pins[2] = 1'b0;
        watch(5, seen);
        check(!seen, "R4 one-sample glitch rejected", seen, 0);
        pins[1] = 1'b1; step(); step(); pins[1] = 1'b0;
        watch(5, seen);
        check(!seen, "R4 two-sample glitch rejected", seen, 0);
        check(flag == 1'b1, "R4 flag kept", flag, 1);
        pins[1] = 1'b1;
        watch(3, seen);
        check(seen, "R4 armed after glitches", seen, 1);
    endtask

    task automatic t_disabled();
        bit seen;
        do_reset(4'h0, 1'b0);
        wake_dis = 1'b1;
        arm();
        pins = 4'hF; slow_pin = 1'b1;
        watch(10, seen);
        check(!seen, "R6 no wake when disabled", seen, 0);
        check(flag == 1'b1, "R6 flag kept when disabled", flag, 1);
    endtask

    task automatic t_slow_pin();
        do_reset(4'h0, 1'b1);
        arm();
        slow_pin = 1'b0;
        step(); step(); step();
        check(wake_rst == 1'b1, "R7 slow pin wake", wake_rst, 1);
        check(flag == 1'b0, "R7 shared flag", flag, 0);
    endtask

    task automatic t_awake_ignored();
        bit seen;
        do_reset(4'h0, 1'b0);
        pins = 4'hA; slow_pin = 1'b1;
        watch(8, seen);
        check(!seen, "R8 awake change ignored", seen, 0);
        check(flag == 1'b1, "R8 flag unchanged", flag, 1);
    endtask

    task automatic t_rearm();
        bit seen;
        do_reset(4'h0, 1'b0);
        arm();
        pins[0] = 1'b1;
        step(); step();
        arm();
        watch(8, seen);
        check(!seen, "R10 new reference absorbs level", seen, 0);
        check(flag == 1'b1, "R2 flag set by sleep", flag, 1);
        pins[3] = 1'b1;
        step(); step();
        check(wake_rst == 1'b0, "R10 count restarted", wake_rst, 0);
        step();
        check(wake_rst == 1'b1, "R2 reference captured, wake", wake_rst, 1);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_sustained(0, 1'b0);
        t_sustained(3, 1'b1);
        t_glitches();
        t_disabled();
        t_slow_pin();
        t_awake_ignored();
        t_rearm();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule